// File: doc/BRIEF.md
# Prescaled Baud Tick Generator

This block produces the timing strobes for an asynchronous serial port. It takes a count source and divides it by a programmable reload value plus one to make a 16x oversampling strobe. A fixed divide-by-16 stage then turns that strobe into the bit-period strobe. The count source is picked by a two-bit select: the system clock itself, the system clock divided by 8, the system clock divided by 32, or the rising edges of an external clock pin. The resulting bit rate is source / (16 * (n + 1)).

Both strobes are clock enables in the system clock domain, each one cycle wide. Software writes the divider value and the source select together through a one-cycle write strobe. The write also restarts every counter in the chain, so the first period after a change has its full length. While the serial port is disabled, the chain is held at its start point and stays silent.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted and after it is released, with `run_en` low, `tick16` and `tick1` are 0. After reset the divider value is 0 and the source select is 00.
- R2: With source select 00 (system clock, no prescale) and divider value n, consecutive `tick16` pulses are n+1 cycles apart.
- R3: With source select 01 (system clock divided by 8), consecutive `tick16` pulses are 8*(n+1) cycles apart.
- R4: With source select 10 (system clock divided by 32), consecutive `tick16` pulses are 32*(n+1) cycles apart.
- R5: With source select 11, each rising edge of `ext_clk` counts as one source step once it has passed a two-flop synchronizer. Consecutive `tick16` pulses are therefore n+1 external periods apart.
- R6: `tick1` is asserted together with every 16th `tick16` and never without it, so its period is 16 times the `tick16` period.
- R7: A cycle with `cfg_we` high loads `cfg_div` and `cfg_src` and restarts the chain. Call the source period P (1, 8 or 32). Counting the rising edges after the write edge, the first `tick16` is visible after edge P*(n+1) and the first `tick1` after edge 16*P*(n+1). No `tick16` is visible right after a write edge.
- R8: While `run_en` is low, no tick is produced and the chain is held at its start point, and a write still loads the configuration. When `run_en` goes high, the first `tick16` is visible after the P*(n+1)-th rising edge, counting the first edge at which `run_en` is high.
- R9: Each `tick16` is one cycle wide whenever P*(n+1) >= 2, and each `tick1` is always one cycle wide. With source 00 and n = 0, `tick16` is high on every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Serial port enable; low holds the chain and silences the ticks |
| cfg_we | input | 1 | One-cycle write strobe for divider value and source select |
| cfg_div | input | 8 | Divider value n written on `cfg_we` |
| cfg_src | input | 2 | Source select written on `cfg_we`: 00 /1, 01 /8, 10 /32, 11 external |
| ext_clk | input | 1 | External count clock, asynchronous to `clk` |
| tick16 | output | 1 | 16x oversampling strobe, one system-clock cycle wide |
| tick1 | output | 1 | Bit-period strobe, one system-clock cycle wide |

## Verification
The assertions take for granted that `cfg_we` is a single-cycle strobe and that `ext_clk` stays high and low for at least two system-clock cycles each, so that the synchronizer never loses an edge. They also assume `run_en` and the configuration inputs are synchronous to `clk`. The stimulus drives every input at the falling edge. It toggles the external clock only every four cycles and keeps each write strobe one cycle long, with writes made both while the chain is running and while it is held idle.

// File: rtl/brg_pkg.sv
package brg_pkg;

  typedef enum logic [1:0] {
    SRC_DIV1  = 2'b00,
    SRC_DIV8  = 2'b01,
    SRC_DIV32 = 2'b10,
    SRC_EXT   = 2'b11
  } brg_src_e;

endpackage

// File: rtl/brg_prescale.sv
module brg_prescale
  import brg_pkg::*;
#(
  parameter int MID_LOG2    = 3,
  parameter int SLOW_LOG2   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     restart,
  input  brg_src_e src,
  input  logic     ext_clk,
  output logic     src_pulse
);

  localparam int EDGE_W = SYNC_STAGES + 1;

  logic [SLOW_LOG2-1:0] pre_cnt_q, pre_cnt_d;
  logic [EDGE_W-1:0]    ext_q, ext_d;
  logic                 ext_rise;
  logic                 sel_pulse;

  // free-running prescale counter, cleared on restart or while idle
  always_comb begin
    if (restart || !run) pre_cnt_d = '0;
    else                 pre_cnt_d = pre_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt_q <= '0;
    else        pre_cnt_q <= pre_cnt_d;
  end

  // synchronizer chain plus one stage for edge detection
  generate
    for (genvar i = 0; i < EDGE_W; i++) begin : g_sync
      if (i == 0) begin : g_first
        assign ext_d[i] = ext_clk;
      end else begin : g_next
        assign ext_d[i] = ext_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= ext_d;
  end

  assign ext_rise = ext_q[SYNC_STAGES-1] & ~ext_q[SYNC_STAGES];

  always_comb begin
    case (src)
      SRC_DIV1:  sel_pulse = 1'b1;
      SRC_DIV8:  sel_pulse = &pre_cnt_q[MID_LOG2-1:0];
      SRC_DIV32: sel_pulse = &pre_cnt_q;
      SRC_EXT:   sel_pulse = ext_rise;
      default:   sel_pulse = 1'b0;
    endcase
  end

  assign src_pulse = run & ~restart & sel_pulse;

endmodule

// File: rtl/brg_reload.sv
module brg_reload #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] load_val,
  input  logic             src_pulse,
  output logic             ovs_strobe,
  output logic [DIV_W-1:0] cnt_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run) begin
      cnt_d = load_val;
    end else if (src_pulse) begin
      if (at_zero) cnt_d = load_val;
      else         cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ovs_strobe = src_pulse & at_zero;
  assign cnt_o      = cnt_q;

endmodule

// File: rtl/brg_oversample.sv
module brg_oversample #(
  parameter int OVS_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ovs_strobe,
  output logic bit_strobe
);

  logic [OVS_LOG2-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (clr)             phase_d = '0;
    else if (ovs_strobe) phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign bit_strobe = ovs_strobe & (&phase_q);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import brg_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int MID_LOG2    = 3,
  parameter int SLOW_LOG2   = 5,
  parameter int OVS_LOG2    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_src,
  input  logic             ext_clk,
  output logic             tick16,
  output logic             tick1
);

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;
  logic [DIV_W-1:0]      div_q, div_d;
  brg_src_e              src_q, src_d;
  logic                  src_pulse;
  logic                  ovs_c, bit_c;
  logic [DIV_W-1:0]      reload_cnt;
  logic                  tick16_q, tick1_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  // configuration registers
  always_comb begin
    div_d = div_q;
    src_d = src_q;
    if (cfg_we) begin
      div_d = cfg_div;
      src_d = brg_src_e'(cfg_src);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      div_q <= '0;
      src_q <= SRC_DIV1;
    end else begin
      div_q <= div_d;
      src_q <= src_d;
    end
  end

  brg_prescale #(
    .MID_LOG2   (MID_LOG2),
    .SLOW_LOG2  (SLOW_LOG2),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run_en),
    .restart  (cfg_we),
    .src      (src_q),
    .ext_clk  (ext_clk),
    .src_pulse(src_pulse)
  );

  brg_reload #(
    .DIV_W(DIV_W)
  ) u_reload (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (run_en),
    .restart   (cfg_we),
    .load_val  (div_d),
    .src_pulse (src_pulse),
    .ovs_strobe(ovs_c),
    .cnt_o     (reload_cnt)
  );

  brg_oversample #(
    .OVS_LOG2(OVS_LOG2)
  ) u_ovs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (cfg_we | ~run_en),
    .ovs_strobe(ovs_c),
    .bit_strobe(bit_c)
  );

  // registered strobes
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tick16_q <= 1'b0;
      tick1_q  <= 1'b0;
    end else begin
      tick16_q <= ovs_c;
      tick1_q  <= bit_c;
    end
  end

  assign tick16 = tick16_q;
  assign tick1  = tick1_q;

endmodule

// File: rtl/brg_chk.sv
module brg_chk
  import brg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             cfg_we,
  input brg_src_e         src_q,
  input logic [DIV_W-1:0] div_q,
  input logic [DIV_W-1:0] reload_cnt,
  input logic             tick16,
  input logic             tick1
);

  // R6
  bit_in_ovs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick1 |-> tick16);

  // R8
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!tick16 && !tick1));

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !tick16);

  // R9
  ovs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && src_q != SRC_DIV1) |=> !tick16);

  // R9
  bit_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick1 |=> !tick1);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_cnt <= div_q);

endmodule

bind baud_tick_gen brg_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .run_en    (run_en),
  .cfg_we    (cfg_we),
  .src_q     (src_q),
  .div_q     (div_q),
  .reload_cnt(reload_cnt),
  .tick16    (tick16),
  .tick1     (tick1)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;

  localparam real CLK_NS = 8.0;
  localparam int  NVEC   = 8;

  // {src[1:0], n[7:0], expected tick16 period[11:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {2'd0, 8'd3,   12'd4},
    {2'd0, 8'd19,  12'd20},
    {2'd1, 8'd4,   12'd40},
    {2'd2, 8'd2,   12'd96},
    {2'd1, 8'd0,   12'd8},
    {2'd2, 8'd0,   12'd32},
    {2'd0, 8'd255, 12'd256},
    {2'd0, 8'd0,   12'd1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_en;
  logic       cfg_we;
  logic [7:0] cfg_div;
  logic [1:0] cfg_src;
  logic       ext_clk;
  logic       tick16, tick1;

  int checks = 0;
  int errors = 0;
  bit ext_on = 1'b0;
  int ext_ph = 0;

  always #(CLK_NS/2.0) clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
    .cfg_div(cfg_div), .cfg_src(cfg_src), .ext_clk(ext_clk),
    .tick16(tick16), .tick1(tick1)
  );

  initial begin
    ext_clk = 1'b0;
    forever begin
      @(negedge clk);
      if (ext_on) begin
        ext_ph++;
        if (ext_ph == 4) begin
          ext_clk = ~ext_clk;
          ext_ph  = 0;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] s, input logic [7:0] n);
    @(negedge clk);
    cfg_src = s; cfg_div = n; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // counts rising edges from the next one; records first/second tick16 and first tick1
  task automatic measure(input int limit, output int f16, output int s16,
                         output int f1, output int dbl);
    int k = 0;
    bit prev = 1'b0;
    f16 = -1; s16 = -1; f1 = -1; dbl = 0;
    while (k < limit && (s16 < 0 || f1 < 0)) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (tick16) begin
        if (f16 < 0) f16 = k;
        else if (s16 < 0) s16 = k;
        if (prev) dbl++;
      end
      if (tick1 && f1 < 0) f1 = k;
      prev = tick16;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f16, s16, f1, dbl, cnt;
    rst_n = 1'b0; run_en = 1'b0; cfg_we = 1'b0; cfg_div = '0; cfg_src = '0;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 tick16 in reset", int'(tick16), 0);
    check("R1 tick1 in reset", int'(tick1), 0);
    rst_n = 1'b1;
    cnt = 0;
    repeat (10) begin
      @(negedge clk);
      cnt += int'(tick16) + int'(tick1);
    end
    check("R1 idle after reset", cnt, 0);
    run_en = 1'b1;

    // vector table: R2/R3/R4 period, R6 tick1, R7 restart latency
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  s   = VEC[i][21:20];
      logic [7:0]  n   = VEC[i][19:12];
      int          exp = int'(VEC[i][11:0]);
      string       tag = (s == 2'd0) ? "R2" : (s == 2'd1) ? "R3" : "R4";
      write_cfg(s, n);
      measure(16*exp + 8, f16, s16, f1, dbl);
      check({"R7 first tick16 ", tag}, f16, exp);
      check({tag, " tick16 period"}, s16 - f16, exp);
      check("R6 R7 first tick1", f1, 16*exp);
      if (exp >= 2) check("R9 tick16 single cycle", dbl, 0);
    end

    // R9 source 00, n = 0: tick16 every cycle
    write_cfg(2'd0, 8'd0);
    cnt = 0;
    repeat (20) begin
      @(negedge clk);
      cnt += int'(tick16);
    end
    check("R9 continuous tick16", cnt, 20);

    // R6 tick1 count over a long window at n=1 /1: every 16th of tick16
    write_cfg(2'd0, 8'd1);
    cnt = 0; f16 = 0;
    repeat (320) begin
      @(negedge clk);
      cnt += int'(tick1);
      f16 += int'(tick16);
    end
    check("R6 tick16 count", f16, 160);
    check("R6 tick1 count", cnt, 10);

    // R8 idle hold, write while idle, restart latency on enable
    write_cfg(2'd1, 8'd1);
    repeat (5) @(negedge clk);
    run_en = 1'b0;
    cnt = 0;
    @(negedge clk);
    repeat (40) begin
      @(negedge clk);
      cnt += int'(tick16) + int'(tick1);
    end
    write_cfg(2'd0, 8'd3);
    repeat (10) begin
      @(negedge clk);
      cnt += int'(tick16) + int'(tick1);
    end
    check("R8 no ticks while idle", cnt, 0);
    run_en = 1'b1;
    measure(16*4 + 8, f16, s16, f1, dbl);
    check("R8 first tick16 after enable", f16, 4);
    check("R8 first tick1 after enable", f1, 64);

    // R5 external source, ext period 8 cycles, n = 2
    ext_on = 1'b1;
    write_cfg(2'd3, 8'd2);
    measure(16*24 + 64, f16, s16, f1, dbl);
    check("R5 tick16 period external", s16 - f16, 24);
    measure(16*24 + 64, f16, s16, f1, dbl);
    check("R5 tick16 period external again", s16 - f16, 24);
    ext_on = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule